// File: doc/BRIEF.md
# Same-PC Warp Merging Pool

This block holds a small pool of partial warps, each described by a program counter, an active-lane mask and one thread id for every lane. Partial warps typically come from branch divergence, where one warp becomes two entries that carry the same threads at two different PCs with complementary masks. The pool packs such fragments back together. An incoming fragment that sits at the same PC as a stored one, and whose lanes do not collide with it, is folded into that entry. Every thread stays in its home lane, so a merge is a bitwise OR of the masks plus a lane-by-lane choice of thread id.

Producers push one fragment per cycle. A stall flag tells them in the same cycle that a fragment could be neither merged nor stored, and was therefore not taken. The consumer sees the oldest stored warp on the pop outputs at all times and takes it by raising a pop request, which frees that slot at the next clock edge. Choosing which PCs to run and deciding where threads reconverge are left to the surrounding logic.

Top module: `warp_merge_pool`

## Requirements
- R1: After reset the pool is empty: pop_valid is 0, and ins_full is 0 while no insertion is offered.
- R2: An insertion with a nonzero mask that finds no merge candidate is stored in the lowest-numbered free slot. It keeps its PC, its mask and all per-lane thread ids.
- R3: A stored entry is a merge candidate when its PC equals ins_pc and its mask ANDed with ins_mask is zero. The insertion merges into the lowest-numbered candidate. The entry's mask becomes the OR of both masks, and for every lane set in ins_mask the entry's thread id for that lane (bits lane*TID_W upward) becomes the incoming one. A merge never removes a lane from an entry.
- R4: An insertion whose PC differs from a stored entry's PC, or whose mask shares at least one lane with it, does not merge into that entry.
- R5: An insertion with an all-zero mask is discarded. It changes no entry and never raises ins_full.
- R6: ins_full is 1 in the cycle of an insertion with a nonzero mask that finds neither a merge candidate nor a free slot. That insertion is dropped. ins_full is never 1 in any other case.
- R7: pop_valid is 1 exactly when at least one entry is stored. pop_pc, pop_mask and pop_tid then show the entry whose slot was allocated earliest; merging does not change an entry's age. When pop_valid and pop_req are both 1, that entry is removed at the clock edge.
- R8: In a cycle in which a pop is taken, the popped entry is not a merge candidate. Its slot is also not free for that cycle's insertion.
- R9: Lanes of pop_tid whose mask bit is 0 carry no defined value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | A fragment is offered this cycle |
| ins_pc | input | PC_W | PC of the offered fragment |
| ins_mask | input | LANES | Active lanes of the offered fragment |
| ins_tid | input | LANES*TID_W | Thread id per lane, lane 0 in the low bits |
| ins_full | output | 1 | Offered fragment was neither merged nor stored |
| pop_req | input | 1 | Take the oldest stored warp |
| pop_valid | output | 1 | At least one warp is stored |
| pop_pc | output | PC_W | PC of the oldest warp |
| pop_mask | output | LANES | Mask of the oldest warp |
| pop_tid | output | LANES*TID_W | Thread ids of the oldest warp |

## Verification
The hardest case to reach from the ports is the cycle in which a pop is taken while a fragment arrives that would merge only into the warp being popped, with every other slot occupied. That cycle has to raise the stall even though a slot frees at the same edge. A directed sequence fills all slots so that the merge target is the oldest entry, and then offers the matching fragment together with a pop. Random stimulus uses only four PCs and often sends complementary mask pairs, so merges, lane collisions, full stalls and pops on a full pool come up throughout the run.

// File: rtl/warp_merge_pkg.sv
`timescale 1ns/1ps
package warp_merge_pkg;
  typedef enum logic [1:0] {
    INS_NONE  = 2'd0,
    INS_MERGE = 2'd1,
    INS_ALLOC = 2'd2,
    INS_STALL = 2'd3
  } ins_act_e;
endpackage

// File: rtl/wm_first_one.sv
`timescale 1ns/1ps
module wm_first_one #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wm_age_track.sv
`timescale 1ns/1ps
module wm_age_track #(
  parameter int SLOTS = 4,
  localparam int SIW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [SIW-1:0]   alloc_idx,
  input  logic [SLOTS-1:0] valid,
  output logic [SLOTS-1:0] oldest_oh
);
  // older_q[i][j] = 1 when slot i was allocated before slot j
  logic [SLOTS-1:0][SLOTS-1:0] older_q, older_d;

  always_comb begin
    older_d = older_q;
    if (alloc_en) begin
      for (int j = 0; j < SLOTS; j++) begin
        older_d[alloc_idx][j] = 1'b0;
        older_d[j][alloc_idx] = valid[j] && (SIW'(j) != alloc_idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (alloc_en) begin
      older_q <= older_d;
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      oldest_oh[i] = valid[i];
      for (int j = 0; j < SLOTS; j++) begin
        if (j != i && valid[j] && !older_q[i][j]) oldest_oh[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/warp_merge_pool.sv
`timescale 1ns/1ps
module warp_merge_pool
  import warp_merge_pkg::*;
#(
  parameter int LANES = 8,
  parameter int SLOTS = 4,
  parameter int PC_W  = 16,
  parameter int TID_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ins_valid,
  input  logic [PC_W-1:0]        ins_pc,
  input  logic [LANES-1:0]       ins_mask,
  input  logic [LANES*TID_W-1:0] ins_tid,
  output logic                   ins_full,
  input  logic                   pop_req,
  output logic                   pop_valid,
  output logic [PC_W-1:0]        pop_pc,
  output logic [LANES-1:0]       pop_mask,
  output logic [LANES*TID_W-1:0] pop_tid
);
  localparam int SIW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int TW  = LANES * TID_W;

  logic [SLOTS-1:0]            slot_vld;
  logic [SLOTS-1:0][PC_W-1:0]  slot_pc;
  logic [SLOTS-1:0][LANES-1:0] slot_msk;
  logic [SLOTS-1:0][TW-1:0]    slot_tid;
  logic [SLOTS-1:0]            oldest_oh, cand_vec, free_vec;
  logic [SIW-1:0]              old_idx, hit_idx, free_idx;
  logic                        old_any, hit_any, free_any;
  logic                        pop_fire, ins_live;
  ins_act_e                    act;

  wm_age_track #(.SLOTS(SLOTS)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (act == INS_ALLOC),
    .alloc_idx (free_idx),
    .valid     (slot_vld),
    .oldest_oh (oldest_oh)
  );

  wm_first_one #(.N(SLOTS)) u_old  (.req(oldest_oh), .found(old_any),  .idx(old_idx));
  wm_first_one #(.N(SLOTS)) u_hit  (.req(cand_vec),  .found(hit_any),  .idx(hit_idx));
  wm_first_one #(.N(SLOTS)) u_free (.req(free_vec),  .found(free_any), .idx(free_idx));

  assign pop_valid = |slot_vld;
  assign pop_fire  = pop_req && pop_valid;
  assign pop_pc    = slot_pc[old_idx];
  assign pop_mask  = slot_msk[old_idx];
  assign pop_tid   = slot_tid[old_idx];
  assign ins_live  = ins_valid && (|ins_mask);

  always_comb begin
    if (!ins_live)     act = INS_NONE;
    else if (hit_any)  act = INS_MERGE;
    else if (free_any) act = INS_ALLOC;
    else               act = INS_STALL;
  end

  assign ins_full = (act == INS_STALL);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic             vld_q, vld_d, upd;
    logic [PC_W-1:0]  pc_q, pc_d;
    logic [LANES-1:0] msk_q, msk_d;
    logic [TW-1:0]    tid_q, tid_d;

    assign slot_vld[s] = vld_q;
    assign slot_pc[s]  = pc_q;
    assign slot_msk[s] = msk_q;
    assign slot_tid[s] = tid_q;
    // the slot being popped this cycle is excluded from merging
    assign cand_vec[s] = vld_q && (pc_q == ins_pc) && ((msk_q & ins_mask) == '0)
                         && !(pop_fire && oldest_oh[s]);
    assign free_vec[s] = !vld_q;

    always_comb begin
      vld_d = vld_q;
      pc_d  = pc_q;
      msk_d = msk_q;
      tid_d = tid_q;
      upd   = 1'b0;
      if (pop_fire && oldest_oh[s]) begin
        vld_d = 1'b0;
        upd   = 1'b1;
      end
      if (act == INS_MERGE && hit_idx == SIW'(s)) begin
        msk_d = msk_q | ins_mask;
        for (int l = 0; l < LANES; l++) begin
          if (ins_mask[l]) tid_d[l*TID_W +: TID_W] = ins_tid[l*TID_W +: TID_W];
        end
        upd = 1'b1;
      end
      if (act == INS_ALLOC && free_idx == SIW'(s)) begin
        vld_d = 1'b1;
        pc_d  = ins_pc;
        msk_d = ins_mask;
        tid_d = ins_tid;
        upd   = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        pc_q  <= '0;
        msk_q <= '0;
        tid_q <= '0;
      end else if (upd) begin
        vld_q <= vld_d;
        pc_q  <= pc_d;
        msk_q <= msk_d;
        tid_q <= tid_d;
      end
    end
  end
endmodule

// File: rtl/warp_merge_pool_chk.sv
`timescale 1ns/1ps
module warp_merge_pool_chk #(
  parameter int LANES = 8,
  parameter int SLOTS = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ins_valid,
  input logic [LANES-1:0]            ins_mask,
  input logic                        ins_full,
  input logic                        pop_req,
  input logic                        pop_valid,
  input logic [LANES-1:0]            pop_mask,
  input logic [SLOTS-1:0]            slot_vld,
  input logic [SLOTS-1:0][LANES-1:0] slot_msk,
  input logic [SLOTS-1:0]            oldest_oh
);
  AST_POP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> pop_mask != '0); // R5

  AST_FULL_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_full |-> (ins_valid && ins_mask != '0)); // R6

  AST_FULL_NO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_full |-> (&slot_vld)); // R6

  AST_GROW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_vld) <= $past($countones(slot_vld)) + 1); // R2

  AST_OLDEST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> $countones(oldest_oh) == 1); // R7

  AST_POP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && pop_valid) |=> (slot_vld & $past(oldest_oh)) == '0); // R8

  for (genvar s = 0; s < SLOTS; s++) begin : g_keep
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld[s] && !(pop_req && oldest_oh[s]))
        |=> (slot_vld[s] && (($past(slot_msk[s]) & ~slot_msk[s]) == '0))); // R3
  end
endmodule

bind warp_merge_pool warp_merge_pool_chk #(.LANES(LANES), .SLOTS(SLOTS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_mask  (ins_mask),
  .ins_full  (ins_full),
  .pop_req   (pop_req),
  .pop_valid (pop_valid),
  .pop_mask  (pop_mask),
  .slot_vld  (slot_vld),
  .slot_msk  (slot_msk),
  .oldest_oh (oldest_oh)
);

// File: tb/warp_merge_pool_tb_top.sv
`timescale 1ns/1ps
module warp_merge_pool_tb_top;
  localparam int LANES = 8;
  localparam int SLOTS = 4;
  localparam int PC_W  = 16;
  localparam int TID_W = 6;
  localparam int TW    = LANES * TID_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ins_valid = 1'b0;
  logic [PC_W-1:0]  ins_pc = '0;
  logic [LANES-1:0] ins_mask = '0;
  logic [TW-1:0]    ins_tid = '0;
  logic             pop_req = 1'b0;
  logic             ins_full, pop_valid;
  logic [PC_W-1:0]  pop_pc;
  logic [LANES-1:0] pop_mask;
  logic [TW-1:0]    pop_tid;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  // bench model of the pool
  bit               m_vld [SLOTS];
  logic [PC_W-1:0]  m_pc  [SLOTS];
  logic [LANES-1:0] m_msk [SLOTS];
  logic [TW-1:0]    m_tid [SLOTS];
  int               m_age [SLOTS];
  int               age_ctr = 0;

  always #5 clk = ~clk;

  warp_merge_pool #(.LANES(LANES), .SLOTS(SLOTS), .PC_W(PC_W), .TID_W(TID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc),
    .ins_mask(ins_mask), .ins_tid(ins_tid), .ins_full(ins_full),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_pc(pop_pc),
    .pop_mask(pop_mask), .pop_tid(pop_tid)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      finish_run();
    end
  end

  function automatic logic [TW-1:0] lane_bits(logic [LANES-1:0] m);
    logic [TW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*TID_W +: TID_W] = {TID_W{m[l]}};
    return r;
  endfunction

  function automatic int model_oldest();
    int o = -1;
    for (int s = 0; s < SLOTS; s++)
      if (m_vld[s] && (o < 0 || m_age[s] < m_age[o])) o = s;
    return o;
  endfunction

  task automatic cmp(string lbl, string what, logic [63:0] act, logic [63:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%h expected=%h", lbl, what, act, exp);
    end
  endtask

  // one cycle: drive, compare combinational outputs, advance the model
  task automatic step(string lbl, bit iv, logic [PC_W-1:0] pc, logic [LANES-1:0] msk,
                      logic [TW-1:0] tid, bit pr);
    int o, hit, fr;
    bit live, pfire, exp_full;
    @(negedge clk);
    ins_valid = iv; ins_pc = pc; ins_mask = msk; ins_tid = tid; pop_req = pr;
    #1;
    o     = model_oldest();
    pfire = pr && (o >= 0);
    live  = iv && (msk != '0);
    hit = -1; fr = -1;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (m_vld[s] && m_pc[s] == pc && (m_msk[s] & msk) == '0 && !(pfire && s == o)) hit = s;
      if (!m_vld[s]) fr = s;
    end
    exp_full = live && hit < 0 && fr < 0;
    cmp(lbl, "ins_full", 64'(ins_full), 64'(exp_full));
    cmp(lbl, "pop_valid", 64'(pop_valid), 64'(o >= 0));
    if (o >= 0) begin
      cmp(lbl, "pop_pc", 64'(pop_pc), 64'(m_pc[o]));
      cmp(lbl, "pop_mask", 64'(pop_mask), 64'(m_msk[o]));
      cmp(lbl, "pop_tid R9", 64'(pop_tid & lane_bits(m_msk[o])),
          64'(m_tid[o] & lane_bits(m_msk[o])));
    end
    if (pfire) m_vld[o] = 1'b0;
    if (live && hit >= 0) begin
      for (int l = 0; l < LANES; l++)
        if (msk[l]) m_tid[hit][l*TID_W +: TID_W] = tid[l*TID_W +: TID_W];
      m_msk[hit] = m_msk[hit] | msk;
    end else if (live && fr >= 0) begin
      m_vld[fr] = 1'b1; m_pc[fr] = pc; m_msk[fr] = msk; m_tid[fr] = tid;
      m_age[fr] = age_ctr; age_ctr = age_ctr + 1;
    end
  endtask

  function automatic logic [TW-1:0] rtid();
    return TW'({$urandom(), $urandom()});
  endfunction

  initial begin
    logic [LANES-1:0] pend_msk;
    logic [PC_W-1:0]  pend_pc;
    logic [TW-1:0]    pend_tid;
    bit               pend;
    void'($urandom(32'd1234));
    for (int s = 0; s < SLOTS; s++) begin
      m_vld[s] = 0; m_pc[s] = '0; m_msk[s] = '0; m_tid[s] = '0; m_age[s] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    cmp("R1 in reset", "pop_valid", 64'(pop_valid), 64'(0));
    cmp("R1 in reset", "ins_full", 64'(ins_full), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    step("R1 idle", 0, '0, '0, '0, 0);

    // zero mask is discarded
    step("R5 zero mask", 1, 16'h5, 8'h00, rtid(), 0);
    step("R5 after zero mask", 0, '0, '0, '0, 0);

    // allocate, merge, collisions
    step("R2 alloc", 1, 16'h1, 8'h0F, rtid(), 0);
    step("R3 merge", 1, 16'h1, 8'hF0, rtid(), 0);
    step("R4 overlap", 1, 16'h1, 8'h01, rtid(), 0);
    step("R4 other pc", 1, 16'h2, 8'hF0, rtid(), 0);
    step("R3 merge second", 1, 16'h2, 8'h0F, rtid(), 0);
    step("R2 fill", 1, 16'h3, 8'h01, rtid(), 0);
    step("R6 full stall", 1, 16'h4, 8'h01, rtid(), 0);
    step("R6 full merge ok", 1, 16'h3, 8'h02, rtid(), 0);
    step("R5 zero when full", 1, 16'h9, 8'h00, rtid(), 0);
    for (int i = 0; i < SLOTS + 1; i++) step("R7 drain", 0, '0, '0, '0, 1);

    // pop taken while a fragment targets the popped entry on a full pool
    step("R8 fill a", 1, 16'h7, 8'h0F, rtid(), 0);
    step("R8 fill b", 1, 16'h8, 8'h0F, rtid(), 0);
    step("R8 fill c", 1, 16'h9, 8'h0F, rtid(), 0);
    step("R8 fill d", 1, 16'hA, 8'h0F, rtid(), 0);
    step("R8 pop vs merge", 1, 16'h7, 8'hF0, rtid(), 1);
    step("R8 retry", 1, 16'h7, 8'hF0, rtid(), 0);
    step("R7 age after merge", 1, 16'h8, 8'hF0, rtid(), 1);
    step("R7 age check", 0, '0, '0, '0, 0);

    // constrained random: four PCs, divergent pairs
    pend = 0; pend_msk = '0; pend_pc = '0; pend_tid = '0;
    for (int i = 0; i < 4000; i++) begin
      bit iv, pr;
      logic [LANES-1:0] m;
      logic [PC_W-1:0]  p;
      logic [TW-1:0]    t;
      iv = ($urandom_range(0, 9) < 7);
      pr = ($urandom_range(0, 9) < 3);
      if (pend && $urandom_range(0, 1) == 1) begin
        m = pend_msk; p = pend_pc; t = pend_tid; pend = 0;
      end else begin
        m = LANES'($urandom());
        if ($urandom_range(0, 15) == 0) m = '0;
        p = PC_W'($urandom_range(0, 3));
        t = rtid();
        if ($urandom_range(0, 1) == 1) begin
          pend = 1; pend_msk = ~m; pend_pc = PC_W'($urandom_range(0, 3)); pend_tid = t;
        end
      end
      step("R3 R4 R6 R7 random", iv, p, m, t, pr);
    end
    finish_run();
  end
endmodule